// File: doc/BRIEF.md
# Double-Buffered PWM Timer Channel

This block is one pulse-width-modulation timer channel. It has a down-counter and a compare register, and software never writes either of them directly. Software loads two shadow buffers, one for the period count and one for the compare threshold. The buffer contents move into the live registers along one of two paths:

- a manual-load strobe, used while the channel is stopped, which arms the channel;
- an automatic reload, which fires when a running count has expired.

The channel advances only on cycles where an external tick enable is high. That tick comes from a prescaler that sits outside this block.

The usual sequence has two control writes:

1. With `start` low, raise `manual_load` together with `auto_reload` to arm the channel.
2. In one write, raise `start` and drop `manual_load`.

From then on the counter counts down from the loaded value to zero, once per tick. On the tick after it reaches zero it reloads from the buffers, so the waveform repeats every count+1 ticks. If software writes only the compare buffer while the channel runs, the duty cycle changes at the next reload and not before.

The buffer write ports and the control pins are plain level or strobe signals with no valid/ready handshake. A write is always accepted on the cycle it is presented, so no back-pressure is possible.

Top module: `pwm_dbuf_chan`

## Requirements
- R1: After reset, `pwm_o` and `expire_o` are low, and the active count, active compare and both buffers are zero.
- R2: A write to either buffer takes effect in the buffer on the next clock edge. It changes neither the active count nor the active compare, nor the output, until a manual load or an automatic reload moves it across.
- R3: On every clock edge where `manual_load` is high, the active count and compare take the buffer values held before that edge. While `manual_load` is high the counter does not decrement and `pwm_o` is low.
- R4: The counter decrements by one on each edge where `tick_en`, `start` and not `manual_load` are all true. Without a tick it holds its value.
- R5: While `start` is high and `manual_load` is low, `pwm_o` is high when the active count is strictly below the active compare and low otherwise. When `start` is low, `pwm_o` is low.
- R6: A tick that moves the counter from 1 to 0 makes `expire_o` high for exactly the following clock cycle. A count buffer of zero never produces a pulse.
- R7: A tick that finds the counter at 0 while `auto_reload` is high reloads both active registers from the buffers. With a count buffer of N, the waveform therefore repeats every N+1 ticks.
- R8: With `auto_reload` low, a counter at 0 stays at 0 on further ticks and gives no further expiry pulses.
- R9: An active compare of 0 gives a constantly low output. An active compare of N+1 or more, where N is the loaded count, gives a constantly high output while the channel runs.
- R10: A compare-buffer write made while running leaves the current period unchanged and is applied from the next reload onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle count enable from the external prescaler |
| start | input | 1 | Run control; low stops the channel and forces the output low |
| manual_load | input | 1 | Copies both buffers into the active registers while high |
| auto_reload | input | 1 | Enables reload from the buffers when the count expires |
| cnt_wr_en | input | 1 | Write strobe for the count buffer |
| cnt_wr_data | input | W | New count buffer value |
| cmp_wr_en | input | 1 | Write strobe for the compare buffer |
| cmp_wr_data | input | W | New compare buffer value |
| pwm_o | output | 1 | PWM output level |
| expire_o | output | 1 | One-cycle pulse after the counter reaches zero |

## Verification
The bench runs the channel with four kinds of input pattern:

- **Every-cycle ticks and sparse ticks.** These separate decrement-per-tick from decrement-per-clock.
- **A mid-period compare rewrite.** This shows whether the compare value is taken from the buffer or from the live register.
- **Compare values of zero and of count+1.** These expose an off-by-one in the threshold test.
- **Expiry with the reload enable low.** This separates a sticky zero from a silent wrap.

In each pattern, writes to the buffers without any transfer confirm that the shadowing hides them from the output.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
  // What the active registers do on a given clock edge.
  typedef enum logic [1:0] {
    XF_HOLD   = 2'd0,
    XF_MANUAL = 2'd1,
    XF_RELOAD = 2'd2,
    XF_DEC    = 2'd3
  } xfer_e;
endpackage

// File: rtl/pwm_shadow_buf.sv
module pwm_shadow_buf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wd,
  input  logic         cmp_we,
  input  logic [W-1:0] cmp_wd,
  output logic [W-1:0] cnt_buf,
  output logic [W-1:0] cmp_buf
);
  // Software-visible shadows; never touched by the counting path.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_buf <= '0;
      cmp_buf <= '0;
    end else begin
      if (cnt_we) cnt_buf <= cnt_wd;
      if (cmp_we) cmp_buf <= cmp_wd;
    end
  end
endmodule

// File: rtl/pwm_xfer_ctrl.sv
module pwm_xfer_ctrl
  import pwm_dbuf_pkg::*;
(
  input  logic  start,
  input  logic  manual_load,
  input  logic  auto_reload,
  input  logic  tick_en,
  input  logic  cnt_zero,
  output xfer_e xfer,
  output logic  running
);
  // Manual load wins over everything; counting needs start and a tick.
  always_comb begin
    running = start && !manual_load;
    xfer    = XF_HOLD;
    if (manual_load) begin
      xfer = XF_MANUAL;
    end else if (start && tick_en) begin
      if (!cnt_zero)        xfer = XF_DEC;
      else if (auto_reload) xfer = XF_RELOAD;
      else                  xfer = XF_HOLD;
    end
  end
endmodule

// File: rtl/pwm_down_cnt.sv
module pwm_down_cnt
  import pwm_dbuf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  xfer_e        xfer,
  input  logic [W-1:0] cnt_buf,
  input  logic [W-1:0] cmp_buf,
  output logic [W-1:0] act_cnt,
  output logic [W-1:0] act_cmp,
  output logic         cnt_zero,
  output logic         expire
);
  localparam logic [W-1:0] ONE = W'(1);

  assign cnt_zero = (act_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_cnt <= '0;
      act_cmp <= '0;
      expire  <= 1'b0;
    end else begin
      // Pulse only on the 1 -> 0 step of a decrement.
      expire <= (xfer == XF_DEC) && (act_cnt == ONE);
      unique case (xfer)
        XF_MANUAL, XF_RELOAD: begin
          act_cnt <= cnt_buf;
          act_cmp <= cmp_buf;
        end
        XF_DEC:  act_cnt <= act_cnt - ONE;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pwm_level.sv
module pwm_level #(
  parameter int W = 8
) (
  input  logic         running,
  input  logic [W-1:0] act_cnt,
  input  logic [W-1:0] act_cmp,
  output logic         pwm
);
  // Strict compare: threshold 0 never asserts, threshold above count always does.
  assign pwm = running && (act_cnt < act_cmp);
endmodule

// File: rtl/pwm_dbuf_chan.sv
module pwm_dbuf_chan
  import pwm_dbuf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         start,
  input  logic         manual_load,
  input  logic         auto_reload,
  input  logic         cnt_wr_en,
  input  logic [W-1:0] cnt_wr_data,
  input  logic         cmp_wr_en,
  input  logic [W-1:0] cmp_wr_data,
  output logic         pwm_o,
  output logic         expire_o
);
  logic [W-1:0] cnt_buf, cmp_buf;
  logic [W-1:0] act_cnt, act_cmp;
  logic         cnt_zero, running;
  xfer_e        xfer;

  pwm_shadow_buf #(.W(W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .cnt_we(cnt_wr_en), .cnt_wd(cnt_wr_data),
    .cmp_we(cmp_wr_en), .cmp_wd(cmp_wr_data),
    .cnt_buf(cnt_buf), .cmp_buf(cmp_buf)
  );

  pwm_xfer_ctrl u_ctrl (
    .start(start), .manual_load(manual_load), .auto_reload(auto_reload),
    .tick_en(tick_en), .cnt_zero(cnt_zero),
    .xfer(xfer), .running(running)
  );

  pwm_down_cnt #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .xfer(xfer),
    .cnt_buf(cnt_buf), .cmp_buf(cmp_buf),
    .act_cnt(act_cnt), .act_cmp(act_cmp),
    .cnt_zero(cnt_zero), .expire(expire_o)
  );

  pwm_level #(.W(W)) u_lvl (
    .running(running), .act_cnt(act_cnt), .act_cmp(act_cmp), .pwm(pwm_o)
  );
endmodule

// File: rtl/pwm_dbuf_chan_chk.sv
module pwm_dbuf_chan_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_en,
  input logic         start,
  input logic         manual_load,
  input logic         auto_reload,
  input logic         pwm_o,
  input logic         expire_o,
  input logic [W-1:0] act_cnt,
  input logic [W-1:0] act_cmp,
  input logic [W-1:0] cnt_buf,
  input logic [W-1:0] cmp_buf
);
  assert_manual_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    manual_load |=> (act_cnt == $past(cnt_buf)) && (act_cmp == $past(cmp_buf)));

  assert_manual_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    manual_load |-> !pwm_o);

  assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !manual_load) |=> $stable(act_cnt));

  assert_stopped_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !start |-> !pwm_o);

  assert_expire_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |-> (act_cnt == '0));

  assert_expire_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o);

  assert_sticky_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_cnt == '0) && !auto_reload && !manual_load) |=> (act_cnt == '0));

  assert_cmp_zero_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_cmp == '0) |-> !pwm_o);
endmodule

bind pwm_dbuf_chan pwm_dbuf_chan_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start(start),
  .manual_load(manual_load), .auto_reload(auto_reload),
  .pwm_o(pwm_o), .expire_o(expire_o),
  .act_cnt(act_cnt), .act_cmp(act_cmp), .cnt_buf(cnt_buf), .cmp_buf(cmp_buf)
);

// File: tb/pwm_dbuf_chan_tb.sv
`timescale 1ns/1ps
module pwm_dbuf_chan_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, start = 1'b0, manual_load = 1'b0, auto_reload = 1'b0;
  logic cnt_wr_en = 1'b0, cmp_wr_en = 1'b0;
  logic [W-1:0] cnt_wr_data = '0, cmp_wr_data = '0;
  logic pwm_o, expire_o;

  always #5 clk = ~clk;

  pwm_dbuf_chan #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start(start),
    .manual_load(manual_load), .auto_reload(auto_reload),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
    .pwm_o(pwm_o), .expire_o(expire_o)
  );

  typedef struct {
    logic  pwm;
    logic  exp;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 0;

  // Reference state built from the requirements.
  logic [W-1:0] m_cnt = '0, m_cmp = '0, m_cbuf = '0, m_pbuf = '0;
  bit g_tick = 0, g_start = 0, g_man = 0, g_ar = 0;

  // Driver: applies one cycle of stimulus and pushes the expected outputs.
  task automatic cyc(input string tag, input bit cwe, input logic [W-1:0] cwd,
                     input bit pwe, input logic [W-1:0] pwd);
    exp_t e;
    @(negedge clk);
    tick_en = g_tick; start = g_start; manual_load = g_man; auto_reload = g_ar;
    cnt_wr_en = cwe; cnt_wr_data = cwd; cmp_wr_en = pwe; cmp_wr_data = pwd;
    @(posedge clk);
    e.exp = !g_man && g_start && g_tick && (m_cnt == W'(1));   // R6
    if (g_man) begin                                           // R3
      m_cnt = m_cbuf; m_cmp = m_pbuf;
    end else if (g_start && g_tick) begin
      if (m_cnt != '0) m_cnt = m_cnt - W'(1);                  // R4
      else if (g_ar) begin m_cnt = m_cbuf; m_cmp = m_pbuf; end // R7, R8 otherwise
    end
    if (cwe) m_cbuf = cwd;                                     // R2
    if (pwe) m_pbuf = pwd;
    e.pwm = g_start && !g_man && (m_cnt < m_cmp);              // R5
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(tag, 1'b0, '0, 1'b0, '0);
  endtask

  // Monitor: compares just after each edge, well clear of input changes.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (expire_o) pulses++;
        if (pwm_o !== e.pwm || expire_o !== e.exp) begin
          errors++;
          $display("FAIL %s: pwm=%b expire=%b expected pwm=%b expire=%b",
                   e.tag, pwm_o, expire_o, e.pwm, e.exp);
        end
      end
    end
  end

  task automatic direct(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs low while held in reset
    direct("R1 pwm in reset", int'(pwm_o), 0);
    direct("R1 expire in reset", int'(expire_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: active registers zero, so starting without a load stays low
    g_start = 1; g_tick = 1;
    idle(3, "R1 post-reset run");
    g_start = 0; g_tick = 0;

    // R2: write buffers while stopped; nothing moves
    cyc("R2 write cnt", 1'b1, 8'd4, 1'b1, 8'd2);
    g_start = 1; g_tick = 1;
    idle(3, "R2 no transfer yet");
    g_start = 0;

    // R3: arm with manual load and auto-reload, start low
    g_man = 1; g_ar = 1;
    idle(2, "R3 manual load");
    // R4 R5 R6 R7: run, one tick per clock
    g_man = 0; g_start = 1;
    pulses = 0;
    idle(15, "R7 periodic run");
    #3;
    direct("R7 three expiries in 15 ticks", pulses, 3);

    // R4: sparse ticks
    for (int i = 0; i < 6; i++) begin
      g_tick = 1; idle(1, "R4 sparse tick");
      g_tick = 0; idle(2, "R4 hold between ticks");
    end
    g_tick = 1;

    // R10: compare rewrite mid-period applies at next reload (5 >= 4+1 -> always high)
    cyc("R10 compare write", 1'b0, '0, 1'b1, 8'd5);
    idle(12, "R10 applied at reload");
    // R9: compare zero -> always low after reload
    cyc("R9 compare zero write", 1'b0, '0, 1'b1, 8'd0);
    idle(12, "R9 compare zero");
    // R2: count buffer write mid-run, seen only at reload
    cyc("R2 count write while running", 1'b1, 8'd2, 1'b1, 8'd1);
    idle(10, "R2 new period after reload");

    // R8: auto-reload off, counter sticks at zero
    g_ar = 0;
    pulses = 0;
    idle(10, "R8 no reload");
    #3;
    direct("R8 at most one expiry", int'(pulses <= 1), 1);

    // R6: zero count buffer never pulses
    cyc("R6 zero count", 1'b1, 8'd0, 1'b1, 8'd3);
    g_start = 0; g_man = 1; g_ar = 1;
    idle(1, "R6 arm zero");
    g_man = 0; g_start = 1;
    pulses = 0;
    idle(6, "R6 zero count run");
    #3;
    direct("R6 no pulse for zero count", pulses, 0);

    // R5: stop forces low
    g_start = 0;
    idle(4, "R5 stopped");

    idle(0, "");
    @(posedge clk); #4;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule